// File: doc/BRIEF.md
# Segmented physical address generator

This block turns a 16-bit segment base plus a 16-bit offset into a 20-bit physical byte address. The segment value is moved up four bit positions before the offset is added. Every segment therefore starts on a 16-byte paragraph boundary and spans 64K bytes. Segments may overlap, so different segment/offset pairs can name the same byte.

The block keeps four segment bases: code, data, extra and stack. Each request states its access kind. A fetch always uses the code base. A stack access (through either stack pointer or base pointer) uses the stack base by default. A data access uses the data base by default. Stack and data requests may carry a segment override that names any of the four bases. Fetches ignore the override.

Each result also carries byte-lane enables for a memory built as an even byte bank and an odd byte bank behind a 16-bit data bus. A word access at an odd address is flagged as misaligned, so that an outside controller can split it into two byte cycles.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, through a single output register:
- A request is taken on any clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the output register is empty, or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment × 16 + offset) modulo 2^20. Any carry out of bit 19 is dropped, so segment FFFFH with offset FFFFH gives 0FFEFH.
- R2: An access of kind 00 (fetch) always uses the code base, whatever the override inputs say.
- R3: An access of kind 01 (stack) without override uses the stack base.
- R4: An access of kind 10 or 11 (data) without override uses the data base.
- R5: For kinds 01, 10 and 11, `req_ovr_en`=1 selects the base named by `req_ovr_sel` (00 code, 01 data, 10 extra, 11 stack).
- R6: When `seg_wr_en` is high on a clock edge, the base named by `seg_wr_sel` (same encoding as R5) takes `seg_wr_data`. A request taken on that same edge still sees the previous value. Requests taken on later edges see the new value.
- R7: With `req_word`=0, an even address enables only `out_even_en` and an odd address enables only `out_odd_en`. With `req_word`=1, an even address enables both banks. In all three cases `out_misalign` is 0.
- R8: With `req_word`=1 and an odd address, `out_misalign` is 1 and both bank enables are 0.
- R9: The result stream behaves as follows:
  - `req_ready` = !`out_valid` || `out_ready`.
  - While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the address, enables and flag stay unchanged.
- R10: After reset, `out_valid` is 0 and all four segment bases are 0.
- R11: A request taken on a clock edge appears on the outputs right after that edge. With `out_ready` held high, a new result can be delivered every cycle. When no request is taken and the output drains, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Write strobe for a segment base |
| seg_wr_sel | input | 2 | Base to write (00 code, 01 data, 10 extra, 11 stack) |
| seg_wr_data | input | 16 | New segment base value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Access kind: 00 fetch, 01 stack, 10/11 data |
| req_ovr_en | input | 1 | Segment override enable (ignored for fetch) |
| req_ovr_sel | input | 2 | Override base, encoded as for seg_wr_sel |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_offset | input | 16 | Offset within the segment |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 20 | Physical byte address |
| out_even_en | output | 1 | Even byte bank enable |
| out_odd_en | output | 1 | Odd byte bank enable |
| out_misalign | output | 1 | Word access at an odd address |

## Verification
The bench drives many segment/offset pairs through every combination of access kind, override setting and access width. It checks each result against the arithmetic in R1 through R8:
- A dropped or misplaced shift would put every segment on the wrong paragraph.
- A carry kept out of bit 19 would show up at segment FFFFH with offset FFFFH.
- A fetch that honours the override would read the wrong base.
- A bank decoder that ignores width or parity would light the wrong lane on odd word accesses.

The bench also checks the boundaries of the register timing:
- A segment write in the same cycle as a request must not be seen by that request.
- Back-pressure must freeze the result and block intake, and a stage that dropped or duplicated a result would break that.
- Back-to-back requests must each surface one cycle after they are taken.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEGS  = 4;
  localparam int SEG_SEL_W = 2;

  typedef enum logic [SEG_SEL_W-1:0] {
    SEG_CODE  = 2'b00,
    SEG_DATA  = 2'b01,
    SEG_EXTRA = 2'b10,
    SEG_STACK = 2'b11
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'b00,
    ACC_STACK    = 2'b01,
    ACC_DATA     = 2'b10,
    ACC_DATA_ALT = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile import seg_pkg::*; #(
  parameter int SEG_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [SEG_SEL_W-1:0]               wr_sel,
  input  logic [SEG_W-1:0]                   wr_data,
  output logic [NUM_SEGS-1:0][SEG_W-1:0]     seg_q
);
  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (wr_en && (wr_sel == SEG_SEL_W'(g))) begin
        seg_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select import seg_pkg::*; #(
  parameter int SEG_W = 16
) (
  input  logic [1:0]                         kind,
  input  logic                               ovr_en,
  input  logic [SEG_SEL_W-1:0]               ovr_sel,
  input  logic [NUM_SEGS-1:0][SEG_W-1:0]     seg_q,
  output logic [SEG_W-1:0]                   seg_val
);
  seg_id_e idx;

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH: idx = SEG_CODE;
      ACC_STACK: idx = ovr_en ? seg_id_e'(ovr_sel) : SEG_STACK;
      default:   idx = ovr_en ? seg_id_e'(ovr_sel) : SEG_DATA;
    endcase
  end

  assign seg_val = seg_q[idx];
endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [SEG_W-1:0]           seg_val,
  input  logic [OFF_W-1:0]           offset,
  output logic [SEG_W+SEG_SHIFT-1:0] addr
);
  localparam int ADDR_W = SEG_W + SEG_SHIFT;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  assign base    = {seg_val, {SEG_SHIFT{1'b0}}};
  assign off_ext = ADDR_W'(offset);
  // Sum kept at ADDR_W bits: the top carry is dropped and the address wraps.
  assign addr    = base + off_ext;
endmodule

// File: rtl/bank_decode.sv
module bank_decode (
  input  logic addr_lsb,
  input  logic is_word,
  output logic even_en,
  output logic odd_en,
  output logic misalign
);
  always_comb begin
    even_en  = 1'b0;
    odd_en   = 1'b0;
    misalign = 1'b0;
    unique case ({is_word, addr_lsb})
      2'b00: even_en = 1'b1;
      2'b01: odd_en  = 1'b1;
      2'b10: begin
        even_en = 1'b1;
        odd_en  = 1'b1;
      end
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen import seg_pkg::*; #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seg_wr_en,
  input  logic [1:0]                 seg_wr_sel,
  input  logic [SEG_W-1:0]           seg_wr_data,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_kind,
  input  logic                       req_ovr_en,
  input  logic [1:0]                 req_ovr_sel,
  input  logic                       req_word,
  input  logic [OFF_W-1:0]           req_offset,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SEG_W+SEG_SHIFT-1:0] out_addr,
  output logic                       out_even_en,
  output logic                       out_odd_en,
  output logic                       out_misalign
);
  localparam int ADDR_W = SEG_W + SEG_SHIFT;

  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]               seg_val;
  logic [ADDR_W-1:0]              phys;
  logic                           even_c;
  logic                           odd_c;
  logic                           mis_c;
  logic                           accept;

  seg_regfile #(.SEG_W(SEG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .seg_q   (seg_q)
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .kind    (req_kind),
    .ovr_en  (req_ovr_en),
    .ovr_sel (req_ovr_sel),
    .seg_q   (seg_q),
    .seg_val (seg_val)
  );

  phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_add (
    .seg_val (seg_val),
    .offset  (req_offset),
    .addr    (phys)
  );

  bank_decode u_bank (
    .addr_lsb (phys[0]),
    .is_word  (req_word),
    .even_en  (even_c),
    .odd_en   (odd_c),
    .misalign (mis_c)
  );

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_even_en  <= 1'b0;
      out_odd_en   <= 1'b0;
      out_misalign <= 1'b0;
    end else begin
      if (req_ready) begin
        out_valid <= req_valid;
      end
      if (accept) begin
        out_addr     <= phys;
        out_even_en  <= even_c;
        out_odd_en   <= odd_c;
        out_misalign <= mis_c;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       seg_wr_en,
  input logic [1:0]                 seg_wr_sel,
  input logic [SEG_W-1:0]           seg_wr_data,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [1:0]                 req_kind,
  input logic                       req_ovr_en,
  input logic [1:0]                 req_ovr_sel,
  input logic                       req_word,
  input logic [OFF_W-1:0]           req_offset,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [SEG_W+SEG_SHIFT-1:0] out_addr,
  input logic                       out_even_en,
  input logic                       out_odd_en,
  input logic                       out_misalign
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_even_en) && $stable(out_odd_en) && $stable(out_misalign)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> req_ready);

  assert_take_shows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);

  assert_lane_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_misalign) |-> (out_even_en || out_odd_en));

  assert_odd_no_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_addr[0]) |-> !out_even_en);

  assert_misalign_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_misalign) |-> (out_addr[0] && !out_even_en && !out_odd_en));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)
) u_chk (.*);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic        req_ovr_en;
  logic [1:0]  req_ovr_sel;
  logic        req_word;
  logic [15:0] req_offset;
  logic        out_valid;
  logic        out_ready;
  logic [19:0] out_addr;
  logic        out_even_en;
  logic        out_odd_en;
  logic        out_misalign;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] mseg [4];

  always #2 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel), .req_word(req_word),
    .req_offset(req_offset), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_even_en(out_even_en), .out_odd_en(out_odd_en),
    .out_misalign(out_misalign)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pa(logic [15:0] s, logic [15:0] o);
    logic [19:0] r;
    r = {s, 4'h0} + {4'h0, o};
    return r;
  endfunction

  function automatic int pick(logic [1:0] k, logic oe, logic [1:0] os);
    if (k == 2'b00) return 0;
    if (oe) return int'(os);
    if (k == 2'b01) return 3;
    return 1;
  endfunction

  function automatic string addr_tag(logic [1:0] k, logic oe);
    if (k == 2'b00) return "R2";
    if (oe) return "R5";
    if (k == 2'b01) return "R3";
    return "R4";
  endfunction

  function automatic logic [2:0] lanes(logic w, logic a0);
    if (w && a0) return 3'b001;
    if (w) return 3'b110;
    if (a0) return 3'b010;
    return 3'b100;
  endfunction

  task automatic check_out(string tag, logic [1:0] k, logic oe, logic [1:0] os,
                           logic w, logic [15:0] off, logic [15:0] segv);
    logic [19:0] ea;
    ea = pa(segv, off);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " addr R1"}, 32'(out_addr), 32'(ea));
    chk((w && ea[0]) ? "R8 lanes" : "R7 lanes",
        32'({out_even_en, out_odd_en, out_misalign}), 32'(lanes(w, ea[0])));
  endtask

  task automatic seg_write(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
    mseg[sel] = val;
  endtask

  task automatic issue(logic [1:0] k, logic oe, logic [1:0] os, logic w, logic [15:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_ovr_en = oe; req_ovr_sel = os;
    req_word = w; req_offset = off; out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(addr_tag(k, oe), k, oe, os, w, off, mseg[pick(k, oe, os)]);
  endtask

  initial begin
    rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = '0; seg_wr_data = '0;
    req_valid = 1'b0; req_kind = '0; req_ovr_en = 1'b0; req_ovr_sel = '0;
    req_word = 1'b0; req_offset = '0; out_ready = 1'b1;
    for (int i = 0; i < 4; i++) mseg[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk("R10 out_valid", 32'(out_valid), 32'd0);
    chk("R9 ready when empty", 32'(req_ready), 32'd1);
    issue(2'b10, 1'b0, 2'b00, 1'b0, 16'h1234);   // R10 bases zero -> addr = offset

    // R1: worked examples
    seg_write(2'b01, 16'h1000);
    issue(2'b10, 1'b0, 2'b00, 1'b0, 16'h2000);   // 12000H
    seg_write(2'b00, 16'h1400);
    issue(2'b00, 1'b0, 2'b00, 1'b1, 16'h1200);   // 15200H
    seg_write(2'b11, 16'h2000);
    issue(2'b01, 1'b0, 2'b00, 1'b1, 16'h3000);   // 23000H
    seg_write(2'b10, 16'h52B9);
    seg_write(2'b11, 16'h5D27);
    issue(2'b01, 1'b1, 2'b10, 1'b0, 16'hD470);   // 60000H via override
    issue(2'b01, 1'b0, 2'b00, 1'b0, 16'h2D90);   // 60000H via stack
    seg_write(2'b01, 16'hFFFF);
    issue(2'b10, 1'b0, 2'b00, 1'b1, 16'hFFFF);   // R1 wrap -> 0FFEFH, misaligned (R8)

    // R6: write and request in the same cycle, request sees old base
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'b01; seg_wr_data = 16'hABCD;
    req_valid = 1'b1; req_kind = 2'b11; req_ovr_en = 1'b0; req_ovr_sel = 2'b00;
    req_word = 1'b0; req_offset = 16'h0010; out_ready = 1'b1;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    chk("R6 same-cycle old base", 32'(out_addr), 32'(pa(16'hFFFF, 16'h0010)));
    mseg[1] = 16'hABCD;
    issue(2'b11, 1'b0, 2'b00, 1'b0, 16'h0010);   // R6 new base now visible

    // Sweep of bases, kinds, overrides, widths and offsets
    for (int s = 0; s < 8; s++) begin
      for (int r = 0; r < 4; r++) begin
        seg_write(2'(r), (s == 7) ? 16'hFFFF : 16'(16'h0F00 + s * 16'h2357 + r * 16'h1111));
      end
      for (int k = 0; k < 4; k++)
        for (int oe = 0; oe < 2; oe++)
          for (int os = 0; os < 4; os++)
            for (int w = 0; w < 2; w++)
              for (int oi = 0; oi < 4; oi++) begin
                logic [15:0] off;
                case (oi)
                  0: off = 16'h0000;
                  1: off = 16'hFFFF;
                  2: off = 16'(s * 16'h1F3 + k * 16'h31 + os);
                  default: off = 16'(16'h8001 + s * 16'h0202 + w);
                endcase
                issue(2'(k), 1'(oe), 2'(os), 1'(w), off);
              end
    end

    // R11: back-to-back, one result per cycle
    seg_write(2'b01, 16'h4000);
    @(negedge clk);
    out_ready = 1'b1;
    req_valid = 1'b1; req_kind = 2'b10; req_ovr_en = 1'b0; req_word = 1'b0;
    req_offset = 16'h0000;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R11 back-to-back", 32'({out_valid, out_addr}),
          32'({1'b1, pa(16'h4000, 16'(i - 1))}));
      req_offset = 16'(i);
    end
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 drain", 32'(out_valid), 32'd0);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; req_offset = 16'h00A0;
    @(negedge clk);
    req_offset = 16'h00B1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 ready low under stall", 32'(req_ready), 32'd0);
      chk("R9 held result", 32'({out_valid, out_addr, out_even_en, out_odd_en}),
          32'({1'b1, pa(16'h4000, 16'h00A0), 2'b10}));
    end
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next result after release", 32'({out_valid, out_addr, out_even_en, out_odd_en}),
        32'({1'b1, pa(16'h4000, 16'h00B1), 2'b01}));
    @(negedge clk);
    chk("R11 empty after drain", 32'(out_valid), 32'd0);

    summary();
  end
endmodule